// File: doc/BRIEF.md
# Synchronized Receive Reset Controller

This block lets two linked receivers line up their sample streams. It watches the control-word bus for writes to one synchronisation address. From each such word it keeps a link-enable flag. It can also raise one of two single-cycle strobes: a full receive reset, or a reset of the numerically controlled oscillators (NCOs) only.

Inside it sits a bank of phase accumulators, one per receive channel, each stepped by its own frequency word. The NCO reset zeroes every accumulator on the same clock, so any pair of channels ends up phase-aligned. The full reset stands in for the wider receive path. It clears a packet sequence counter and a decimation counter, and it holds an upstream-stall output high for a short fixed window while the flush takes effect.

Typical use: set matching channel frequencies on both radios, enable the link, issue one full reset after the clocks are locked, then issue cheaper NCO resets as needed. Each command word must keep the link bit set if the link is to stay enabled.

Top module: `rxsync_ctrl`

## Requirements
- R1: On every cycle with `cmdValid` high and `cmdAddr` equal to SYNC_ADDR (default 6'h39), `linkEnable` takes the value of `cmdData[31]` on the next cycle. This includes words that carry reset bits and words that carry conflicting reset bits. At all other times `linkEnable` holds its value.
- R2: A valid write to SYNC_ADDR with `cmdData[25]`=1 and `cmdData[24]`=0 drives `rstAllPulse` high during the single following cycle. Every such word does this, including back-to-back repeats of the same word.
- R3: A valid write to SYNC_ADDR with `cmdData[24]`=1 and `cmdData[25]`=0 drives `rstNcoPulse` high during the single following cycle. Every such word does this.
- R4: A valid write to SYNC_ADDR with both `cmdData[25]` and `cmdData[24]` set raises neither pulse.
- R5: A word presented with `cmdValid` low, or addressed anywhere other than SYNC_ADDR, raises no pulse and leaves `linkEnable` unchanged.
- R6: In the cycle after `rstNcoPulse`, every channel's phase in `phaseBus` (channel c at bits [32c+31:32c]) reads zero. A full reset leaves the phases untouched.
- R7: Each clock, every accumulator adds its frequency word. A frequency word is loaded from `freqWord` into channel `freqSel` on a cycle with `freqWe` high. k cycles after a zeroing, channel c reads k*freq[c] modulo 2^32.
- R8: `seqNum` increments on each cycle with `pktDone` high. It reads zero in the cycle after `rstAllPulse`.
- R9: `decimCount` steps through 0 to DECIM-1 (default 5) once per clock and wraps. It reads zero in the cycle after `rstAllPulse`.
- R10: `upstreamStall` is high for exactly STALL_CYC cycles (default 4), starting in the cycle after `rstAllPulse`. A further full reset during the window restarts it.
- R11: While `rst_n` is low, `linkEnable`, both pulses, all phases, `seqNum`, `decimCount` and `upstreamStall` are zero, and the frequency words are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Control word present this cycle |
| cmdAddr | input | ADDR_W | Control word address |
| cmdData | input | 32 | Control word payload |
| freqWe | input | 1 | Load a channel frequency word |
| freqSel | input | CH_W | Channel chosen for the frequency load |
| freqWord | input | PHASE_W | Frequency word value |
| pktDone | input | 1 | One packet sent upstream this cycle |
| linkEnable | output | 1 | Inter-radio link enabled |
| rstAllPulse | output | 1 | Full receive reset strobe |
| rstNcoPulse | output | 1 | NCO-only reset strobe |
| phaseBus | output | NUM_CH*PHASE_W | Concatenated channel phases |
| seqNum | output | SEQ_W | Packet sequence counter |
| decimCount | output | DECIM_W | Decimation phase counter |
| upstreamStall | output | 1 | Upstream output held off |

## Verification
A wrong decode in the control register shows up one cycle after the command, as a missing, extra or doubled strobe, or as a link flag that moved when it should have held. A fault in the accumulator clear shows in the very next cycle as a non-zero phase. A wrong step shows as a drift from k*freq that grows with every cycle after the zeroing. Errors in the sequence, decimation and stall logic appear within STALL_CYC+DECIM cycles of a full reset, as a wrong count value or a stall window of the wrong length.

// File: rtl/rxsync_pkg.sv
`timescale 1ns/1ps
package rxsync_pkg;
  localparam int LINK_BIT = 31;
  localparam int ALL_BIT  = 25;
  localparam int NCO_BIT  = 24;

  typedef struct packed {
    logic clrAll;
    logic clrNco;
  } strobe_t;
endpackage

// File: rtl/rxsync_cmd.sv
`timescale 1ns/1ps
module rxsync_cmd
  import rxsync_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] SYNC_ADDR = 6'h39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdData,
  output logic              linkEnable,
  output strobe_t           strobe
);
  logic hit;
  logic wantAll;
  logic wantNco;
  strobe_t strobeNext;

  always_comb begin
    hit     = cmdValid && (cmdAddr == SYNC_ADDR);
    wantAll = cmdData[ALL_BIT];
    wantNco = cmdData[NCO_BIT];
    strobeNext.clrAll = hit && wantAll && !wantNco;
    strobeNext.clrNco = hit && wantNco && !wantAll;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      linkEnable <= 1'b0;
      strobe     <= '0;
    end else begin
      if (hit) linkEnable <= cmdData[LINK_BIT];
      strobe <= strobeNext;
    end
  end
endmodule

// File: rtl/rxsync_nco_bank.sv
`timescale 1ns/1ps
module rxsync_nco_bank #(
  parameter int NUM_CH  = 4,
  parameter int PHASE_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clrNco,
  input  logic                      freqWe,
  input  logic [CH_W-1:0]           freqSel,
  input  logic [PHASE_W-1:0]        freqWord,
  output logic [NUM_CH*PHASE_W-1:0] phaseBus
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [PHASE_W-1:0] freqReg;
    logic [PHASE_W-1:0] acc;
    logic               loadHere;

    assign loadHere = freqWe && (freqSel == CH_W'(ch));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        freqReg <= '0;
      end else if (loadHere) begin
        freqReg <= freqWord;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clrNco) begin
        acc <= '0;
      end else begin
        acc <= acc + freqReg;
      end
    end

    assign phaseBus[ch*PHASE_W +: PHASE_W] = acc;
  end
endmodule

// File: rtl/rxsync_datapath.sv
`timescale 1ns/1ps
module rxsync_datapath
  import rxsync_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int PHASE_W   = 32,
  parameter int SEQ_W     = 32,
  parameter int DECIM     = 5,
  parameter int STALL_CYC = 4,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DECIM_W  = (DECIM > 1) ? $clog2(DECIM) : 1,
  localparam int STALL_W  = $clog2(STALL_CYC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  strobe_t                   strobe,
  input  logic                      freqWe,
  input  logic [CH_W-1:0]           freqSel,
  input  logic [PHASE_W-1:0]        freqWord,
  input  logic                      pktDone,
  output logic [NUM_CH*PHASE_W-1:0] phaseBus,
  output logic [SEQ_W-1:0]          seqNum,
  output logic [DECIM_W-1:0]        decimCount,
  output logic                      upstreamStall
);
  localparam logic [DECIM_W-1:0] DECIM_LAST = DECIM_W'(DECIM - 1);
  localparam logic [STALL_W-1:0] STALL_LOAD = STALL_W'(STALL_CYC);

  logic [STALL_W-1:0] stallLeft;

  rxsync_nco_bank #(
    .NUM_CH (NUM_CH),
    .PHASE_W(PHASE_W)
  ) i_nco_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clrNco  (strobe.clrNco),
    .freqWe  (freqWe),
    .freqSel (freqSel),
    .freqWord(freqWord),
    .phaseBus(phaseBus)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clrAll) begin
      seqNum <= '0;
    end else if (pktDone) begin
      seqNum <= seqNum + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clrAll) begin
      decimCount <= '0;
    end else if (decimCount == DECIM_LAST) begin
      decimCount <= '0;
    end else begin
      decimCount <= decimCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stallLeft <= '0;
    end else if (strobe.clrAll) begin
      stallLeft <= STALL_LOAD;
    end else if (stallLeft != '0) begin
      stallLeft <= stallLeft - 1'b1;
    end
  end

  assign upstreamStall = (stallLeft != '0);
endmodule

// File: rtl/rxsync_ctrl.sv
`timescale 1ns/1ps
module rxsync_ctrl
  import rxsync_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] SYNC_ADDR = 6'h39,
  parameter int NUM_CH    = 4,
  parameter int PHASE_W   = 32,
  parameter int SEQ_W     = 32,
  parameter int DECIM     = 5,
  parameter int STALL_CYC = 4,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DECIM_W  = (DECIM > 1) ? $clog2(DECIM) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmdValid,
  input  logic [ADDR_W-1:0]         cmdAddr,
  input  logic [31:0]               cmdData,
  input  logic                      freqWe,
  input  logic [CH_W-1:0]           freqSel,
  input  logic [PHASE_W-1:0]        freqWord,
  input  logic                      pktDone,
  output logic                      linkEnable,
  output logic                      rstAllPulse,
  output logic                      rstNcoPulse,
  output logic [NUM_CH*PHASE_W-1:0] phaseBus,
  output logic [SEQ_W-1:0]          seqNum,
  output logic [DECIM_W-1:0]        decimCount,
  output logic                      upstreamStall
);
  strobe_t strobe;

  rxsync_cmd #(
    .ADDR_W   (ADDR_W),
    .SYNC_ADDR(SYNC_ADDR)
  ) i_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmdValid  (cmdValid),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .linkEnable(linkEnable),
    .strobe    (strobe)
  );

  rxsync_datapath #(
    .NUM_CH   (NUM_CH),
    .PHASE_W  (PHASE_W),
    .SEQ_W    (SEQ_W),
    .DECIM    (DECIM),
    .STALL_CYC(STALL_CYC)
  ) i_datapath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .freqWe       (freqWe),
    .freqSel      (freqSel),
    .freqWord     (freqWord),
    .pktDone      (pktDone),
    .phaseBus     (phaseBus),
    .seqNum       (seqNum),
    .decimCount   (decimCount),
    .upstreamStall(upstreamStall)
  );

  assign rstAllPulse = strobe.clrAll;
  assign rstNcoPulse = strobe.clrNco;
endmodule

// File: rtl/rxsync_chk.sv
`timescale 1ns/1ps
module rxsync_chk #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] SYNC_ADDR = 6'h39,
  parameter int NUM_CH  = 4,
  parameter int PHASE_W = 32,
  parameter int SEQ_W   = 32,
  parameter int DECIM_W = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmdValid,
  input logic [ADDR_W-1:0]         cmdAddr,
  input logic [31:0]               cmdData,
  input logic                      linkEnable,
  input logic                      rstAllPulse,
  input logic                      rstNcoPulse,
  input logic [NUM_CH*PHASE_W-1:0] phaseBus,
  input logic [SEQ_W-1:0]          seqNum,
  input logic [DECIM_W-1:0]        decimCount,
  input logic                      upstreamStall
);
  logic hitNow;
  assign hitNow = cmdValid && (cmdAddr == SYNC_ADDR);

  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hitNow |=> $stable(linkEnable)); // R1

  AST_ALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    hitNow && cmdData[25] && !cmdData[24] |=> rstAllPulse); // R2

  AST_NCO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    hitNow && cmdData[24] && !cmdData[25] |=> rstNcoPulse); // R3

  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rstAllPulse && rstNcoPulse)); // R4

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !hitNow |=> !rstAllPulse && !rstNcoPulse); // R5

  AST_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rstNcoPulse |=> (phaseBus == '0)); // R6

  AST_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rstAllPulse |=> (seqNum == '0) && (decimCount == '0)); // R8

  AST_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
    rstAllPulse |=> upstreamStall); // R10
endmodule

bind rxsync_ctrl rxsync_chk #(
  .ADDR_W   (ADDR_W),
  .SYNC_ADDR(SYNC_ADDR),
  .NUM_CH   (NUM_CH),
  .PHASE_W  (PHASE_W),
  .SEQ_W    (SEQ_W),
  .DECIM_W  (DECIM_W)
) i_chk (.*);

// File: tb/test_rxsync_ctrl.sv
`timescale 1ns/1ps
module test_rxsync_ctrl;
  localparam int NUM_CH = 4;
  localparam int DECIM  = 5;
  localparam int STALL_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [5:0] cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic freqWe = 1'b0;
  logic [1:0] freqSel = '0;
  logic [31:0] freqWord = '0;
  logic pktDone = 1'b0;
  logic linkEnable, rstAllPulse, rstNcoPulse, upstreamStall;
  logic [NUM_CH*32-1:0] phaseBus;
  logic [31:0] seqNum;
  logic [2:0] decimCount;

  int nTests = 0;
  int nFails = 0;
  int kPh = 0;
  int kDec = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rxsync_ctrl i_rxsync_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .freqWe(freqWe), .freqSel(freqSel), .freqWord(freqWord),
    .pktDone(pktDone), .linkEnable(linkEnable), .rstAllPulse(rstAllPulse),
    .rstNcoPulse(rstNcoPulse), .phaseBus(phaseBus), .seqNum(seqNum),
    .decimCount(decimCount), .upstreamStall(upstreamStall)
  );

  typedef struct packed {
    logic [5:0]  addr;
    logic [31:0] data;
    logic        expAll;
    logic        expNco;
    logic        expLink;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{6'h39, 32'h8000_0000, 1'b0, 1'b0, 1'b1},
    '{6'h39, 32'h8200_0000, 1'b1, 1'b0, 1'b1},
    '{6'h39, 32'h8200_0000, 1'b1, 1'b0, 1'b1},
    '{6'h39, 32'h8100_0000, 1'b0, 1'b1, 1'b1},
    '{6'h39, 32'h8300_0000, 1'b0, 1'b0, 1'b1},
    '{6'h38, 32'h0300_0000, 1'b0, 1'b0, 1'b1},
    '{6'h39, 32'h0200_0000, 1'b1, 1'b0, 1'b0},
    '{6'h39, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    '{6'h3A, 32'h8100_0000, 1'b0, 1'b0, 1'b0},
    '{6'h39, 32'h8100_0000, 1'b0, 1'b1, 1'b1}
  };

  function automatic logic [31:0] freqOf(int ch);
    return 32'h0123_4567 * 32'(ch + 1) + 32'(ch * 977);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    kPh++;
    kDec++;
  endtask

  task automatic sendCmd(input logic [5:0] a, input logic [31:0] d);
    cmdValid = 1'b1;
    cmdAddr  = a;
    cmdData  = d;
    tick();
    cmdValid = 1'b0;
  endtask

  task automatic chkPhases(input string req);
    for (int ch = 0; ch < NUM_CH; ch++)
      chk(req, phaseBus[ch*32 +: 32], 32'(kPh) * freqOf(ch));
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 link", {31'b0, linkEnable}, 32'd0);
    chk("R11 pulses", {30'b0, rstAllPulse, rstNcoPulse}, 32'd0);
    chk("R11 phase", phaseBus[31:0] | phaseBus[127:96], 32'd0);
    chk("R11 seq", seqNum, 32'd0);
    chk("R11 decim", {29'b0, decimCount}, 32'd0);
    chk("R11 stall", {31'b0, upstreamStall}, 32'd0);
    rst_n = 1'b1;
    tick();

    // R1 R2 R3 R4 R5 command decode table
    for (int i = 0; i < 10; i++) begin
      sendCmd(VEC[i].addr, VEC[i].data);
      chk("R2 allPulse", {31'b0, rstAllPulse}, {31'b0, VEC[i].expAll});
      chk("R3 ncoPulse", {31'b0, rstNcoPulse}, {31'b0, VEC[i].expNco});
      chk("R1 link", {31'b0, linkEnable}, {31'b0, VEC[i].expLink});
    end
    tick();

    // R5 invalid strobe carries reset bits and cleared link bit
    cmdAddr = 6'h39;
    cmdData = 32'h0200_0000;
    tick();
    chk("R5 no pulse", {30'b0, rstAllPulse, rstNcoPulse}, 32'd0);
    chk("R5 link kept", {31'b0, linkEnable}, 32'd1);

    // R7 load frequency words
    for (int ch = 0; ch < NUM_CH; ch++) begin
      freqWe = 1'b1;
      freqSel = 2'(ch);
      freqWord = freqOf(ch);
      tick();
    end
    freqWe = 1'b0;

    // R3 R6 NCO reset zeroes all channels together
    sendCmd(6'h39, 32'h8100_0000);
    chk("R3 pulse high", {31'b0, rstNcoPulse}, 32'd1);
    tick();
    kPh = 0;
    chk("R3 one cycle", {31'b0, rstNcoPulse}, 32'd0);
    chkPhases("R6 zero");
    repeat (5) tick();
    chkPhases("R7 advance");

    // R8 sequence counting
    pktDone = 1'b1;
    repeat (6) tick();
    pktDone = 1'b0;
    chk("R8 seq count", seqNum, 32'd6);

    // R8 R9 R10 R6 full reset
    sendCmd(6'h39, 32'h8200_0000);
    chk("R2 pulse high", {31'b0, rstAllPulse}, 32'd1);
    tick();
    kDec = 0;
    chk("R2 one cycle", {31'b0, rstAllPulse}, 32'd0);
    chk("R8 seq cleared", seqNum, 32'd0);
    chk("R9 decim cleared", {29'b0, decimCount}, 32'd0);
    chkPhases("R6 untouched by full reset");
    for (int j = 1; j < STALL_CYC; j++) begin
      chk("R10 stall held", {31'b0, upstreamStall}, 32'd1);
      tick();
    end
    chk("R10 stall last", {31'b0, upstreamStall}, 32'd1);
    tick();
    chk("R10 stall ends", {31'b0, upstreamStall}, 32'd0);
    repeat (3) tick();
    chk("R9 decim wrap", {29'b0, decimCount}, 32'(kDec % DECIM));
    chkPhases("R7 long run");

    // R10 restart during window
    sendCmd(6'h39, 32'h8200_0000);
    tick();
    tick();
    sendCmd(6'h39, 32'h8200_0000);
    for (int j = 0; j < STALL_CYC; j++) begin
      tick();
      chk("R10 restarted", {31'b0, upstreamStall}, 32'd1);
    end
    tick();
    chk("R10 restart ends", {31'b0, upstreamStall}, 32'd0);

    // R11 reset clears everything again
    rst_n = 1'b0;
    tick();
    chk("R11 link reset", {31'b0, linkEnable}, 32'd0);
    kPh = 0;
    chkPhases("R11 phases reset");
    rst_n = 1'b1;
    tick();
    kPh = 0;
    chkPhases("R11 freq cleared");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule